// File: doc/BRIEF.md
# Flash Program/Erase Sequence Controller

This block sits between a register bus and an on-chip flash array and controls a program or erase operation from start to finish. Software configures protection, block selection and pulse-clock settings. It then opens a sequence by setting a sequence bit. In program mode, software writes data to array addresses. The block captures those writes into per-block page buffers. In erase mode, a single array write acts as an interlock. Only after the required array write may software raise the high-voltage enable. That enable drives an external pulse timer. The timer reports completion with a one-cycle done strobe.

While a sequence is open, the configuration and mode fields are frozen against writes. Once the high-voltage pulse is running, further array writes are dropped. Clearing the sequence bit closes the operation, drops the pulse, releases the buffers and lifts all locks. Register reads return data one cycle after the read strobe. The page buffer is a plain synchronous memory, so the tools can map it to block RAM.

Top module: `flash_seq_ctrl`

## Requirements
- R1: After synchronous reset, the control register (address 0), configuration register (address 1) and status register (address 2) read 0, and `hv_en` is 0.
- R2: The configuration register (address 1) holds these fields: protect [7:0], block-select [15:8], clock scale [18:16], exponent [20:19] and multiplier [27:21]. It accepts writes only while the sequence bit is 0, and writes made while the sequence bit is 1 are dropped. `tmr_cfg` always equals register bits [27:16].
- R3: In the control register, bit 0 is the sequence bit, bit 1 is erase-select, bit 2 is high-voltage enable, bit 3 is interrupt-enable, bit 4 is CSC and bit 5 is done (read-only). While the sequence bit is 1, erase-select and CSC are locked. Interrupt-enable is also locked when erase-select is 0, and stays writable when erase-select is 1.
- R4: In program mode, the first array write of a sequence latches the page offset from array address bits [12:6]. It also stores the data in the buffer. The status register then shows the page offset in bits [6:0], page-valid in bit 16 and armed in bit 17.
- R5: Every program-mode array write stores its data at the buffer word selected by address bits [5:2] of the block selected by bits [15:13]. Later writes leave the latched page offset unchanged. Buffer word {block, word} reads back at register address 0x80 + block*16 + word.
- R6: A write of 1 to high-voltage enable takes effect only while the sequence bit is 1 and the block is armed. A buffer write arms the block in program mode, and the interlock write arms it in erase mode. Otherwise the bit stays 0.
- R7: While high-voltage enable is 1, array writes are dropped and buffer contents are unchanged.
- R8: A `pulse_done` strobe while high-voltage enable is 1 clears it and sets done. Done is cleared when a new sequence is opened.
- R9: Writing 0 to the sequence bit clears high-voltage enable at once, clears armed, page-valid and the page offset, and unlocks every field.
- R10: Array writes while the sequence bit is 0 are ignored. In erase mode, an array write sets armed but writes no buffer and sets no page-valid.
- R11: `reg_rdata` shows the addressed value in the cycle after `reg_rd` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after `reg_rd` |
| arr_wr | input | 1 | Array write strobe |
| arr_addr | input | 16 | Array byte address |
| arr_wdata | input | 32 | Array write data |
| pulse_done | input | 1 | Pulse timer completion strobe |
| hv_en | output | 1 | High-voltage enable to the pulse timer |
| tmr_cfg | output | 12 | Pulse-clock settings {multiplier, exponent, scale} |

## Verification
The bench targets the interlocks.

- **High-voltage gating:** it tries to set high-voltage enable before any array write, in both modes. A design that did not gate the bit would start a pulse with empty buffers or without the erase interlock.
- **Page offset:** it sends a second program write with a different page field. A design that re-latched the offset would show the new page in status.
- **Writes during the pulse:** it sends an array write while the pulse runs. A design without that lockout would overwrite a buffer word during the pulse.
- **Per-field locks:** it checks the interrupt-enable lock in both modes, and that a locked configuration write leaves the register unchanged.
- **Sequence close:** it closes a sequence while the pulse is still on. A design that failed here would leave `hv_en` high or keep the block armed.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  // control register bit positions
  localparam int B_SEQ   = 0;
  localparam int B_ERASE = 1;
  localparam int B_HV    = 2;
  localparam int B_IE    = 3;
  localparam int B_CSC   = 4;
  localparam int B_DONE  = 5;

  // status register bit positions
  localparam int S_VALID = 16;
  localparam int S_ARMED = 17;

  localparam int CFG_W = 28;

  typedef struct packed {
    logic [6:0] mult;
    logic [1:0] expo;
    logic [2:0] scale;
    logic [7:0] blk_sel;
    logic [7:0] protect;
  } cfg_t;
endpackage

// File: rtl/flash_seq_regs.sv
module flash_seq_regs
  import flash_seq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              wr_cfg,
  input  logic [DATA_W-1:0] wdata,
  input  logic              armed,
  input  logic              pulse_done,
  output logic              seq_q,
  output logic              erase_q,
  output logic              hv_q,
  output logic              ie_q,
  output logic              csc_q,
  output logic              done_q,
  output cfg_t              cfg_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q   <= 1'b0;
      erase_q <= 1'b0;
      hv_q    <= 1'b0;
      ie_q    <= 1'b0;
      csc_q   <= 1'b0;
      done_q  <= 1'b0;
      cfg_q   <= '0;
    end else begin
      if (wr_cfg && !seq_q)
        cfg_q <= cfg_t'(wdata[CFG_W-1:0]);
      if (hv_q && pulse_done) begin
        hv_q   <= 1'b0;
        done_q <= 1'b1;
      end
      if (wr_ctrl) begin
        if (!seq_q) begin
          // idle: mode fields are free; opening a sequence clears done
          seq_q   <= wdata[B_SEQ];
          erase_q <= wdata[B_ERASE];
          ie_q    <= wdata[B_IE];
          csc_q   <= wdata[B_CSC];
          if (wdata[B_SEQ])
            done_q <= 1'b0;
        end else if (!wdata[B_SEQ]) begin
          // closing the sequence drops the pulse at once
          seq_q <= 1'b0;
          hv_q  <= 1'b0;
        end else begin
          if (erase_q)
            ie_q <= wdata[B_IE];
          if (wdata[B_HV] && armed && !hv_q)
            hv_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/flash_seq_capture.sv
module flash_seq_capture #(
  parameter int DATA_W = 32,
  parameter int WORD_W = 4,
  parameter int PAGE_W = 7,
  parameter int BLK_W  = 3
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                seq,
  input  logic                                erase,
  input  logic                                hv,
  input  logic                                arr_wr,
  input  logic [2+WORD_W+PAGE_W+BLK_W-1:0]    arr_addr,
  input  logic [DATA_W-1:0]                   arr_wdata,
  output logic                                buf_we,
  output logic [BLK_W+WORD_W-1:0]             buf_idx,
  output logic [DATA_W-1:0]                   buf_wdata,
  output logic [PAGE_W-1:0]                   page_q,
  output logic                                page_valid,
  output logic                                armed
);
  localparam int WORD_LO = 2;
  localparam int PAGE_LO = WORD_LO + WORD_W;
  localparam int BLK_LO  = PAGE_LO + PAGE_W;

  logic accept;
  logic unused_byte_bits;

  assign unused_byte_bits = ^arr_addr[1:0];
  assign accept    = arr_wr && seq && !hv;
  assign buf_we    = accept && !erase;
  assign buf_idx   = {arr_addr[BLK_LO +: BLK_W], arr_addr[WORD_LO +: WORD_W]};
  assign buf_wdata = arr_wdata;

  always_ff @(posedge clk) begin
    if (rst || !seq) begin
      page_q     <= '0;
      page_valid <= 1'b0;
      armed      <= 1'b0;
    end else if (accept) begin
      armed <= 1'b1;
      if (!erase && !page_valid) begin
        page_q     <= arr_addr[PAGE_LO +: PAGE_W];
        page_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_seq_pagebuf.sv
module flash_seq_pagebuf #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 7
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[ridx];
  end
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WORD_W = 4,
  parameter int PAGE_W = 7,
  parameter int BLK_W  = 3
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             reg_wr,
  input  logic                             reg_rd,
  input  logic [BLK_W+WORD_W:0]            reg_addr,
  input  logic [DATA_W-1:0]                reg_wdata,
  output logic [DATA_W-1:0]                reg_rdata,
  input  logic                             arr_wr,
  input  logic [2+WORD_W+PAGE_W+BLK_W-1:0] arr_addr,
  input  logic [DATA_W-1:0]                arr_wdata,
  input  logic                             pulse_done,
  output logic                             hv_en,
  output logic [11:0]                      tmr_cfg
);
  localparam int IDX_W = BLK_W + WORD_W;
  localparam int RA_W  = IDX_W + 1;

  logic seq_q, erase_q, hv_q, ie_q, csc_q, done_q;
  cfg_t cfg_q;
  logic buf_we, page_valid, armed;
  logic [IDX_W-1:0]  buf_idx;
  logic [DATA_W-1:0] buf_wdata, buf_rdata;
  logic [PAGE_W-1:0] page_q;
  logic wr_ctrl, wr_cfg, is_buf;
  logic [DATA_W-1:0] ctrl_word, cfg_word, stat_word, reg_q;
  logic sel_buf_q;

  assign is_buf  = reg_addr[RA_W-1];
  assign wr_ctrl = reg_wr && !is_buf && (reg_addr[1:0] == 2'd0);
  assign wr_cfg  = reg_wr && !is_buf && (reg_addr[1:0] == 2'd1);

  flash_seq_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wr_cfg(wr_cfg),
    .wdata(reg_wdata), .armed(armed), .pulse_done(pulse_done),
    .seq_q(seq_q), .erase_q(erase_q), .hv_q(hv_q), .ie_q(ie_q),
    .csc_q(csc_q), .done_q(done_q), .cfg_q(cfg_q)
  );

  flash_seq_capture #(
    .DATA_W(DATA_W), .WORD_W(WORD_W), .PAGE_W(PAGE_W), .BLK_W(BLK_W)
  ) u_cap (
    .clk(clk), .rst(rst), .seq(seq_q), .erase(erase_q), .hv(hv_q),
    .arr_wr(arr_wr), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .buf_we(buf_we), .buf_idx(buf_idx), .buf_wdata(buf_wdata),
    .page_q(page_q), .page_valid(page_valid), .armed(armed)
  );

  flash_seq_pagebuf #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .we(buf_we), .widx(buf_idx), .wdata(buf_wdata),
    .ridx(reg_addr[IDX_W-1:0]), .rdata(buf_rdata)
  );

  always_comb begin
    ctrl_word          = '0;
    ctrl_word[B_SEQ]   = seq_q;
    ctrl_word[B_ERASE] = erase_q;
    ctrl_word[B_HV]    = hv_q;
    ctrl_word[B_IE]    = ie_q;
    ctrl_word[B_CSC]   = csc_q;
    ctrl_word[B_DONE]  = done_q;
    cfg_word           = '0;
    cfg_word[CFG_W-1:0] = cfg_q;
    stat_word          = '0;
    stat_word[PAGE_W-1:0] = page_q;
    stat_word[S_VALID] = page_valid;
    stat_word[S_ARMED] = armed;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q     <= '0;
      sel_buf_q <= 1'b0;
    end else if (reg_rd) begin
      sel_buf_q <= is_buf;
      case (reg_addr[1:0])
        2'd0:    reg_q <= ctrl_word;
        2'd1:    reg_q <= cfg_word;
        2'd2:    reg_q <= stat_word;
        default: reg_q <= '0;
      endcase
    end
  end

  assign reg_rdata = sel_buf_q ? buf_rdata : reg_q;
  assign hv_en     = hv_q;
  assign tmr_cfg   = {cfg_q.mult, cfg_q.expo, cfg_q.scale};
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        seq_q,
  input logic        erase_q,
  input logic        hv_q,
  input logic        done_q,
  input logic        armed,
  input logic        page_valid,
  input logic        buf_we,
  input logic        pulse_done,
  input logic [27:0] cfg_q
);
  assert_cfg_locked_R2: assert property (@(posedge clk) disable iff (rst)
    (seq_q && $past(seq_q)) |-> $stable(cfg_q));

  assert_hv_needs_arm_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(hv_q) |-> ($past(armed) && $past(seq_q)));

  assert_no_buf_write_in_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    !(buf_we && hv_q));

  assert_pulse_end_R8: assert property (@(posedge clk) disable iff (rst)
    (hv_q && pulse_done) |=> (!hv_q && done_q));

  assert_close_drops_hv_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(seq_q) |-> !hv_q);

  assert_close_releases_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(seq_q) |=> (!armed && !page_valid));

  assert_idle_no_capture_R10: assert property (@(posedge clk) disable iff (rst)
    !seq_q |-> !buf_we);

  assert_erase_no_buffer_R10: assert property (@(posedge clk) disable iff (rst)
    erase_q |-> !buf_we);
endmodule

bind flash_seq_ctrl flash_seq_chk u_chk (
  .clk(clk), .rst(rst), .seq_q(seq_q), .erase_q(erase_q), .hv_q(hv_q),
  .done_q(done_q), .armed(armed), .page_valid(page_valid), .buf_we(buf_we),
  .pulse_done(pulse_done), .cfg_q(cfg_q)
);

// File: tb/tb_flash_seq_ctrl.sv
module tb_flash_seq_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        arr_wr = 1'b0;
  logic [15:0] arr_addr = '0;
  logic [31:0] arr_wdata = '0;
  logic        pulse_done = 1'b0;
  logic        hv_en;
  logic [11:0] tmr_cfg;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;
  bit          done_run = 1'b0;

  always #4 clk = ~clk;

  flash_seq_ctrl dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .arr_wr(arr_wr),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .pulse_done(pulse_done),
    .hv_en(hv_en), .tmr_cfg(tmr_cfg)
  );

  // monitor: compares read data against the scoreboard queue
  always @(posedge clk) rd_seen <= reg_rd;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (reg_rdata !== e) begin
        fails++;
        $display("FAIL %s: rdata actual=%h expected=%h", t, reg_rdata, e);
      end
    end
  end

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic awr(input logic [15:0] a, input logic [31:0] d);
    arr_wr = 1'b1; arr_addr = a; arr_wdata = d;
    @(negedge clk);
    arr_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_hv(input logic e, input string t);
    checks++;
    if (hv_en !== e) begin
      fails++;
      $display("FAIL %s: hv_en actual=%b expected=%b", t, hv_en, e);
    end
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle();
    // R1 reset state
    rd(8'h00, 32'h0, "R1");
    rd(8'h01, 32'h0, "R1");
    rd(8'h02, 32'h0, "R1");
    chk_hv(1'b0, "R1");
    // R2 config writable while idle; R11 read latency
    wr(8'h01, 32'hFABCDE12);
    rd(8'h01, 32'h0ABCDE12, "R2");
    checks++;
    if (tmr_cfg !== 12'hABC) begin
      fails++;
      $display("FAIL R2: tmr_cfg actual=%h expected=%h", tmr_cfg, 12'hABC);
    end
    // open program sequence with IE=1
    wr(8'h00, 32'h9);
    rd(8'h00, 32'h9, "R11");
    wr(8'h01, 32'h01234567);
    rd(8'h01, 32'h0ABCDE12, "R2");
    // R3 erase/CSC/IE locked in program mode
    wr(8'h00, 32'h13);
    rd(8'h00, 32'h9, "R3");
    // R6 HV before any buffer write
    wr(8'h00, 32'hD);
    rd(8'h00, 32'h9, "R6");
    chk_hv(1'b0, "R6");
    // R4 first program write
    awr(16'h454C, 32'hAAAA0001);
    rd(8'h02, 32'h00030015, "R4");
    rd(8'hA3, 32'hAAAA0001, "R4");
    // R5 later write, different page field
    awr(16'hBFFC, 32'hBBBB0002);
    rd(8'h02, 32'h00030015, "R5");
    rd(8'hDF, 32'hBBBB0002, "R5");
    // R6 HV now allowed
    wr(8'h00, 32'hD);
    rd(8'h00, 32'hD, "R6");
    chk_hv(1'b1, "R6");
    // R7 array write during pulse dropped
    awr(16'h454C, 32'h0000DEAD);
    rd(8'hA3, 32'hAAAA0001, "R7");
    // R8 pulse completion
    pulse_done = 1'b1;
    idle();
    pulse_done = 1'b0;
    idle();
    chk_hv(1'b0, "R8");
    rd(8'h00, 32'h29, "R8");
    // R9 close sequence
    wr(8'h00, 32'h8);
    rd(8'h00, 32'h28, "R9");
    rd(8'h02, 32'h0, "R9");
    wr(8'h01, 32'h01234567);
    rd(8'h01, 32'h01234567, "R9");
    // R10 array write while idle ignored
    awr(16'h454C, 32'h0000BEEF);
    rd(8'h02, 32'h0, "R10");
    rd(8'hA3, 32'hAAAA0001, "R10");
    // erase sequence; R8 done cleared on open
    wr(8'h00, 32'h3);
    rd(8'h00, 32'h3, "R8");
    // R3 IE writable in erase mode
    wr(8'h00, 32'hB);
    rd(8'h00, 32'hB, "R3");
    // R6 HV refused before interlock
    wr(8'h00, 32'hF);
    rd(8'h00, 32'hB, "R6");
    chk_hv(1'b0, "R6");
    // R10 interlock write arms only, no buffer write
    awr(16'hBFFC, 32'h00001234);
    rd(8'h02, 32'h00020000, "R10");
    rd(8'hDF, 32'hBBBB0002, "R10");
    wr(8'h00, 32'hF);
    rd(8'h00, 32'hF, "R6");
    chk_hv(1'b1, "R6");
    // R9 close while pulse on
    wr(8'h00, 32'h0);
    chk_hv(1'b0, "R9");
    rd(8'h00, 32'hA, "R9");
    rd(8'h02, 32'h0, "R9");
    idle();
    done_run = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done_run) break;
    end
    if (!done_run) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run actual=hung expected=complete");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule